// File: doc/BRIEF.md
# Two-Stage Separable Switch Allocator

This block allocates the crossbar of a virtual-channel router with `N_IN` input ports, `N_OUT` output ports and `N_VNET * VC_PER_VNET` virtual channels per port. In every cycle it runs two round-robin stages. First, each input port picks one of its eligible virtual channels. The request of that channel goes to the output port it is routed to. Second, each output port grants one of the input ports that request it. The output virtual channel is chosen inside the second stage, so the block needs no separate channel allocator. A packet's first flit takes the lowest free output channel of its own virtual network, and the block remembers that choice for the later flits of the packet.

The surrounding router supplies three things: a per-channel eligibility vector (the channel is in the allocation stage and may send, credits and free channels already considered), the routed output port of each channel, and whether its front flit ends a packet. It also supplies the free-channel map of every output port. The block returns crossbar grants, the flit tags (output port and output channel), one credit-decrement strobe per grant, a channel-idle strobe for packet ends, and the upstream credit return with its idle flag.

Top module: `sw_alloc`

## Requirements
- R1: After reset every round-robin pointer is 0. When all channels of an input port are eligible, channel 0 wins first, and output port pointers start their scan at input 0.
- R2: Stage one of each input port selects the first eligible channel found when scanning upward from its pointer with wrap-around. The winning channel index appears on `fl_vc_o` when that port is granted.
- R3: A stage-one pointer moves to pointer+1 (wrapping from V-1 to 0) only in a cycle where that input port has a winner. It never jumps to the winner's index.
- R4: A stage-one winner requests exactly the output port routed for its channel. Each output port grants the first requesting input found by scanning upward from its own pointer with wrap-around. The grant is reported on `xb_valid_o` and `xb_src_o` (input index in field o).
- R5: A stage-two pointer moves to pointer+1 (wrapping from N_IN-1 to 0) only in a cycle where that output port issues a grant.
- R6: A granted channel with no recorded output channel takes the lowest-numbered free channel of the granted output port within its own virtual network (network = channel / VC_PER_VNET). That choice is recorded, and later grants of that input channel reuse it whatever the free map shows.
- R7: Each grant raises exactly one bit of `cdec_o`, at index outport*V + output channel. No other bit is raised.
- R8: Each grant raises `crt_valid_o` for that input port. If the flit ends a packet, `crt_idle_o` and `vc_idle_o[in*V+vc]` also rise and the channel's recorded output channel is dropped, so the next packet allocates afresh. Otherwise both stay low.
- R9: All outputs are combinational in the cycle of the request. With no eligible channel, every grant and strobe output is 0. Unused tag fields read 0.
- R10: Each output port grants at most one input, and each input is granted at most one output per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| elig_i | input | N_IN*V | Channel eligible this cycle, index in*V+vc |
| route_i | input | N_IN*V*OW | Routed output port per channel |
| tail_i | input | N_IN*V | Front flit ends its packet |
| ovc_free_i | input | N_OUT*V | Output channel free, index out*V+vc |
| xb_valid_o | output | N_OUT | Output port granted this cycle |
| xb_src_o | output | N_OUT*IW | Granted input per output port |
| fl_go_o | output | N_IN | Input port granted this cycle |
| fl_vc_o | output | N_IN*VW | Granted input channel per input port |
| fl_port_o | output | N_IN*OW | Output port tag for the flit |
| fl_ovc_o | output | N_IN*VW | Output channel tag for the flit |
| cdec_o | output | N_OUT*V | Credit-decrement strobe per output channel |
| vc_idle_o | output | N_IN*V | Input channel set idle |
| crt_valid_o | output | N_IN | Credit returned upstream |
| crt_idle_o | output | N_IN | Returned credit marks the channel idle |

## Verification
Every grant, tag and strobe is due in the same cycle as the eligibility that causes it. Pointer moves and output-channel records show up only one cycle later, in the next cycle's choices. The bench drives all inputs on the falling edge and samples outputs 2 ns later, before the rising edge. It compares them with a bench-side arithmetic model whose pointers and records it advances just after each comparison. Directed cycles place the pointer-step, wrap, virtual-network and record-reuse cases, and a long constrained sweep covers mixed traffic.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // Round-robin scan: first set bit at or after ptr (with wrap), -1 if none.
  function automatic int rr_pick(input logic [31:0] req, input int ptr, input int width);
    int sel;
    int idx;
    sel = -1;
    for (int k = 0; k < 32; k++) begin
      if (k < width && sel < 0) begin
        idx = ptr + k;
        if (idx >= width) idx = idx - width;
        if (req[idx[4:0]]) sel = idx;
      end
    end
    return sel;
  endfunction
endpackage

// File: rtl/sa_rr_arb.sv
module sa_rr_arb #(
  parameter int W = 4,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  req_i,
  output logic          win_o,
  output logic [PW-1:0] idx_o
);
  import sa_pkg::*;

  logic [PW-1:0] ptr_q, ptr_d;
  logic [31:0]   req32;
  int            sel;

  always_comb begin
    req32          = '0;
    req32[W-1:0]   = req_i;
    sel            = rr_pick(req32, int'(ptr_q), W);
    win_o          = (sel >= 0);
    idx_o          = win_o ? PW'(sel) : '0;
    ptr_d          = ptr_q;
    if (win_o) ptr_d = (ptr_q == PW'(W - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (win_o) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/sa_vc_track.sv
module sa_vc_track #(
  parameter int V   = 4,
  parameter int VPN = 2,
  localparam int VW = (V > 1) ? $clog2(V) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt_i,
  input  logic [VW-1:0] vc_i,
  input  logic          tail_i,
  input  logic [V-1:0]  free_i,
  output logic [VW-1:0] ovc_o
);
  logic [V-1:0]  has_q, has_d;
  logic [VW-1:0] rec_q [V];
  logic [VW-1:0] rec_d [V];
  logic [VW-1:0] pick;
  logic          found;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int j = 0; j < V; j++) begin
      if (!found && free_i[j] && (j / VPN == int'(vc_i) / VPN)) begin
        found = 1'b1;
        pick  = VW'(j);
      end
    end
    ovc_o = has_q[vc_i] ? rec_q[vc_i] : pick;
    has_d = has_q;
    rec_d = rec_q;
    if (gnt_i) begin
      has_d[vc_i] = !tail_i;
      rec_d[vc_i] = ovc_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_q <= '0;
      for (int j = 0; j < V; j++) rec_q[j] <= '0;
    end else if (gnt_i) begin
      has_q <= has_d;
      rec_q <= rec_d;
    end
  end
endmodule

// File: rtl/sw_alloc.sv
module sw_alloc #(
  parameter int N_IN        = 3,
  parameter int N_OUT       = 3,
  parameter int N_VNET      = 2,
  parameter int VC_PER_VNET = 2,
  localparam int NV = N_VNET * VC_PER_VNET,
  localparam int IW = (N_IN > 1)  ? $clog2(N_IN)  : 1,
  localparam int OW = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int VW = (NV > 1)    ? $clog2(NV)    : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_IN*NV-1:0]    elig_i,
  input  logic [N_IN*NV*OW-1:0] route_i,
  input  logic [N_IN*NV-1:0]    tail_i,
  input  logic [N_OUT*NV-1:0]   ovc_free_i,
  output logic [N_OUT-1:0]      xb_valid_o,
  output logic [N_OUT*IW-1:0]   xb_src_o,
  output logic [N_IN-1:0]       fl_go_o,
  output logic [N_IN*VW-1:0]    fl_vc_o,
  output logic [N_IN*OW-1:0]    fl_port_o,
  output logic [N_IN*VW-1:0]    fl_ovc_o,
  output logic [N_OUT*NV-1:0]   cdec_o,
  output logic [N_IN*NV-1:0]    vc_idle_o,
  output logic [N_IN-1:0]       crt_valid_o,
  output logic [N_IN-1:0]       crt_idle_o
);
  logic [N_IN-1:0]  s1_win;
  logic [VW-1:0]    s1_vc   [N_IN];
  logic [OW-1:0]    s1_port [N_IN];
  logic [N_IN-1:0]  reqm    [N_OUT];
  logic [N_OUT-1:0] s2_win;
  logic [IW-1:0]    s2_src  [N_OUT];
  logic [N_IN-1:0]  go;
  logic [OW-1:0]    gport   [N_IN];
  logic [NV-1:0]    g_free  [N_IN];
  logic [N_IN-1:0]  g_tail;
  logic [VW-1:0]    g_ovc   [N_IN];

  // Stage one: one arbiter per input port over its channels
  for (genvar i = 0; i < N_IN; i++) begin : g_s1
    sa_rr_arb #(.W(NV)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (elig_i[i*NV +: NV]),
      .win_o (s1_win[i]),
      .idx_o (s1_vc[i])
    );
  end

  // Request matrix [output][input]
  always_comb begin
    for (int i = 0; i < N_IN; i++)
      s1_port[i] = route_i[(i*NV + int'(s1_vc[i]))*OW +: OW];
    for (int o = 0; o < N_OUT; o++)
      for (int i = 0; i < N_IN; i++)
        reqm[o][i] = s1_win[i] && (s1_port[i] == OW'(o));
  end

  // Stage two: one arbiter per output port over input ports
  for (genvar o = 0; o < N_OUT; o++) begin : g_s2
    sa_rr_arb #(.W(N_IN)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (reqm[o]),
      .win_o (s2_win[o]),
      .idx_o (s2_src[o])
    );
  end

  // Fold grants back onto input ports
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      go[i]    = 1'b0;
      gport[i] = '0;
      for (int o = 0; o < N_OUT; o++) begin
        if (s2_win[o] && (s2_src[o] == IW'(i))) begin
          go[i]    = 1'b1;
          gport[i] = OW'(o);
        end
      end
      g_free[i] = ovc_free_i[int'(gport[i])*NV +: NV];
      g_tail[i] = tail_i[i*NV + int'(s1_vc[i])];
    end
  end

  // Output channel selection and record per input port
  for (genvar i = 0; i < N_IN; i++) begin : g_trk
    sa_vc_track #(.V(NV), .VPN(VC_PER_VNET)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .gnt_i  (go[i]),
      .vc_i   (s1_vc[i]),
      .tail_i (g_tail[i]),
      .free_i (g_free[i]),
      .ovc_o  (g_ovc[i])
    );
  end

  always_comb begin
    xb_valid_o  = s2_win;
    fl_go_o     = go;
    crt_valid_o = go;
    crt_idle_o  = go & g_tail;
    cdec_o      = '0;
    vc_idle_o   = '0;
    for (int o = 0; o < N_OUT; o++) begin
      xb_src_o[o*IW +: IW] = s2_win[o] ? s2_src[o] : '0;
      if (s2_win[o]) cdec_o[o*NV + int'(g_ovc[s2_src[o]])] = 1'b1;
    end
    for (int i = 0; i < N_IN; i++) begin
      fl_vc_o[i*VW +: VW]   = go[i] ? s1_vc[i] : '0;
      fl_port_o[i*OW +: OW] = gport[i];
      fl_ovc_o[i*VW +: VW]  = go[i] ? g_ovc[i] : '0;
      if (go[i] && g_tail[i]) vc_idle_o[i*NV + int'(s1_vc[i])] = 1'b1;
    end
  end
endmodule

// File: rtl/sw_alloc_chk.sv
module sw_alloc_chk #(
  parameter int N_IN        = 3,
  parameter int N_OUT       = 3,
  parameter int N_VNET      = 2,
  parameter int VC_PER_VNET = 2,
  localparam int NV = N_VNET * VC_PER_VNET,
  localparam int VW = (NV > 1) ? $clog2(NV) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_IN*NV-1:0]  elig_i,
  input logic [N_IN*NV-1:0]  tail_i,
  input logic [N_OUT-1:0]    xb_valid_o,
  input logic [N_IN-1:0]     fl_go_o,
  input logic [N_IN*VW-1:0]  fl_vc_o,
  input logic [N_IN*VW-1:0]  fl_ovc_o,
  input logic [N_OUT*NV-1:0] cdec_o,
  input logic [N_IN*NV-1:0]  vc_idle_o,
  input logic [N_IN-1:0]     crt_valid_o,
  input logic [N_IN-1:0]     crt_idle_o
);
  AST_ONE_GRANT_EACH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fl_go_o) == $countones(xb_valid_o)); // R10
  AST_CDEC_PER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cdec_o) == $countones(xb_valid_o)); // R7
  AST_CREDIT_PER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(crt_valid_o) == $countones(xb_valid_o)); // R8
  AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vc_idle_o) == $countones(crt_idle_o)); // R8
  AST_IDLE_ONLY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (vc_idle_o & ~tail_i) == '0); // R8
  AST_QUIET_NO_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_i == '0) |-> (xb_valid_o == '0 && cdec_o == '0)); // R9

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      fl_go_o[i] |-> elig_i[i*NV + int'(fl_vc_o[i*VW +: VW])]); // R2
    AST_SAME_VNET: assert property (@(posedge clk) disable iff (!rst_n)
      fl_go_o[i] |-> (int'(fl_ovc_o[i*VW +: VW]) / VC_PER_VNET
                      == int'(fl_vc_o[i*VW +: VW]) / VC_PER_VNET)); // R6
  end
endmodule

bind sw_alloc sw_alloc_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_VNET(N_VNET), .VC_PER_VNET(VC_PER_VNET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .elig_i(elig_i), .tail_i(tail_i),
  .xb_valid_o(xb_valid_o), .fl_go_o(fl_go_o), .fl_vc_o(fl_vc_o),
  .fl_ovc_o(fl_ovc_o), .cdec_o(cdec_o), .vc_idle_o(vc_idle_o),
  .crt_valid_o(crt_valid_o), .crt_idle_o(crt_idle_o)
);

// File: tb/tb_sw_alloc.sv
`timescale 1ns/1ps
module tb_sw_alloc;
  localparam int N = 3, M = 3, VN = 2, VPN = 2, V = VN * VPN;
  localparam int IW = 2, OW = 2, VW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N*V-1:0]    elig_i, tail_i;
  logic [N*V*OW-1:0] route_i;
  logic [M*V-1:0]    ovc_free_i;
  logic [M-1:0]      xb_valid_o;
  logic [M*IW-1:0]   xb_src_o;
  logic [N-1:0]      fl_go_o, crt_valid_o, crt_idle_o;
  logic [N*VW-1:0]   fl_vc_o, fl_ovc_o;
  logic [N*OW-1:0]   fl_port_o;
  logic [M*V-1:0]    cdec_o;
  logic [N*V-1:0]    vc_idle_o;

  always #4 clk = ~clk;

  sw_alloc #(.N_IN(N), .N_OUT(M), .N_VNET(VN), .VC_PER_VNET(VPN)) dut (.*);

  int n_chk = 0, n_bad = 0;
  int ipp [N], opp [M];
  bit has [N][V];
  int rec [N][V];
  bit el [N][V], tl [N][V], fr [M][V];
  int rt [N][V];

  task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
    end
  endtask

  function automatic int lowfree(int o, int v);
    for (int j = 0; j < V; j++)
      if (fr[o][j] && (j / VPN == v / VPN)) return j;
    return -1;
  endfunction

  task automatic run_cycle(string tag);
    bit wok [N]; int wv [N];
    logic [M-1:0] e_xbv; logic [M*IW-1:0] e_src;
    logic [N-1:0] e_go, e_ci; logic [N*VW-1:0] e_vc, e_ovc;
    logic [N*OW-1:0] e_port; logic [M*V-1:0] e_cd; logic [N*V-1:0] e_idle;
    int gi [M];
    @(negedge clk);
    for (int i = 0; i < N; i++)
      for (int v = 0; v < V; v++) begin
        elig_i[i*V+v] = el[i][v];
        tail_i[i*V+v] = tl[i][v];
        route_i[(i*V+v)*OW +: OW] = OW'(rt[i][v]);
      end
    for (int o = 0; o < M; o++)
      for (int j = 0; j < V; j++) ovc_free_i[o*V+j] = fr[o][j];
    #2;
    e_xbv = '0; e_src = '0; e_go = '0; e_ci = '0; e_vc = '0; e_ovc = '0;
    e_port = '0; e_cd = '0; e_idle = '0;
    for (int i = 0; i < N; i++) begin
      wok[i] = 0; wv[i] = 0;
      for (int k = 0; k < V; k++) begin
        int x; x = (ipp[i] + k) % V;
        if (!wok[i] && el[i][x]) begin wok[i] = 1; wv[i] = x; end
      end
    end
    for (int o = 0; o < M; o++) begin
      gi[o] = -1;
      for (int k = 0; k < N; k++) begin
        int x; x = (opp[o] + k) % N;
        if (gi[o] < 0 && wok[x] && rt[x][wv[x]] == o) gi[o] = x;
      end
      if (gi[o] >= 0) begin
        int i, v, ov;
        i = gi[o]; v = wv[i];
        ov = has[i][v] ? rec[i][v] : lowfree(o, v);
        e_xbv[o] = 1'b1;
        e_src[o*IW +: IW] = IW'(i);
        e_go[i] = 1'b1;
        e_vc[i*VW +: VW] = VW'(v);
        e_port[i*OW +: OW] = OW'(o);
        e_ovc[i*VW +: VW] = VW'(ov);
        e_cd[o*V + ov] = 1'b1;
        if (tl[i][v]) begin e_idle[i*V + v] = 1'b1; e_ci[i] = 1'b1; end
        has[i][v] = !tl[i][v];
        rec[i][v] = ov;
        opp[o] = (opp[o] + 1) % M == 0 && M == N ? (opp[o] + 1) % N : (opp[o] + 1) % N;
      end
    end
    for (int i = 0; i < N; i++) if (wok[i]) ipp[i] = (ipp[i] + 1) % V;
    chk(tag, "xb_valid", 64'(xb_valid_o), 64'(e_xbv));
    chk(tag, "xb_src", 64'(xb_src_o), 64'(e_src));
    chk(tag, "fl_go", 64'(fl_go_o), 64'(e_go));
    chk(tag, "fl_vc", 64'(fl_vc_o), 64'(e_vc));
    chk(tag, "fl_port", 64'(fl_port_o), 64'(e_port));
    chk(tag, "fl_ovc", 64'(fl_ovc_o), 64'(e_ovc));
    chk(tag, "cdec", 64'(cdec_o), 64'(e_cd));
    chk(tag, "vc_idle", 64'(vc_idle_o), 64'(e_idle));
    chk(tag, "crt_valid", 64'(crt_valid_o), 64'(e_go));
    chk(tag, "crt_idle", 64'(crt_idle_o), 64'(e_ci));
  endtask

  task automatic clear_stim();
    for (int i = 0; i < N; i++)
      for (int v = 0; v < V; v++) begin el[i][v] = 0; tl[i][v] = 1; rt[i][v] = 0; end
    for (int o = 0; o < M; o++)
      for (int j = 0; j < V; j++) fr[o][j] = 1;
  endtask

  task automatic gen_random();
    for (int o = 0; o < M; o++)
      for (int j = 0; j < V; j++) fr[o][j] = ($urandom % 2) == 1;
    for (int i = 0; i < N; i++)
      for (int v = 0; v < V; v++) begin
        if (!has[i][v]) rt[i][v] = int'($urandom % M);
        tl[i][v] = ($urandom % 3) == 0;
        el[i][v] = ($urandom % 2) == 1;
        if (!has[i][v] && lowfree(rt[i][v], v) < 0) el[i][v] = 0;
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      ipp[i] = 0;
      for (int v = 0; v < V; v++) begin has[i][v] = 0; rec[i][v] = 0; end
    end
    for (int o = 0; o < M; o++) opp[o] = 0;
    clear_stim();
    elig_i = '0; tail_i = '0; route_i = '0; ovc_free_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: nothing eligible, everything quiet
    run_cycle("R9");
    // R1: all channels of input 0 eligible to output 1 after reset
    for (int v = 0; v < V; v++) begin el[0][v] = 1; rt[0][v] = 1; end
    run_cycle("R1");
    clear_stim();
    // R3: pointer steps by one, not to the winner (input 0 pointer now 1)
    el[0][3] = 1; run_cycle("R3");
    clear_stim();
    el[0][0] = 1; el[0][2] = 1; run_cycle("R3");
    clear_stim();
    el[0][1] = 1; el[0][3] = 1; run_cycle("R3");
    clear_stim();
    // R5: three inputs contend for output 2, rotating grants
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < N; i++) begin el[i][0] = 1; rt[i][0] = 2; end
      run_cycle("R5");
    end
    clear_stim();
    // R4 R10: disjoint outputs granted in the same cycle
    el[0][1] = 1; rt[0][1] = 1;
    el[1][1] = 1; rt[1][1] = 0;
    el[2][1] = 1; rt[2][1] = 2;
    run_cycle("R4 R10");
    clear_stim();
    // R6: head picks lowest free in its network, body reuses it
    el[1][2] = 1; rt[1][2] = 0; tl[1][2] = 0;
    for (int j = 0; j < V; j++) fr[0][j] = (j == 3);
    run_cycle("R6");
    for (int j = 0; j < V; j++) fr[0][j] = (j == 2);
    el[1][2] = 1; rt[1][2] = 0; tl[1][2] = 0;
    run_cycle("R6");
    // R8: tail frees the channel, next head allocates afresh
    el[1][2] = 1; rt[1][2] = 0; tl[1][2] = 1;
    run_cycle("R8");
    el[1][2] = 1; rt[1][2] = 0; tl[1][2] = 0;
    run_cycle("R8");
    clear_stim();
    // R2: scan with wrap from the current pointer
    el[2][0] = 1; el[2][3] = 1; rt[2][0] = 1; rt[2][3] = 1;
    run_cycle("R2");
    run_cycle("R2");
    clear_stim();
    // R7: long mixed sweep
    for (int c = 0; c < 3000; c++) begin
      gen_random();
      run_cycle("R2 R4 R5 R6 R7 R8 R10");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule